// File: doc/BRIEF.md
# One-Wire Bus Bit Timing Engine

This block is the timing master for a single open-drain one-wire line. When a command is accepted it generates one of four bus slots: a bus reset with presence detect, a write-0 slot, a write-1 slot or a read slot. Each slot has three parts: a low phase, a sample point measured from release, and a recovery tail. A byte layer runs eight slots back to back, least significant bit first, to write or read a whole byte.

All slot timing is counted in units of one microsecond multiplied by a run-time stretch coefficient. A microsecond is `TICKS_PER_US` system clocks. The block never drives the line high. It only asserts a pull-low enable and reads the line level back. A controller starts an operation with a one-cycle request, waits for `done_o`, and then reads the result outputs.

Top module: `owire_engine`

## Requirements
- R1: Op code 0 (bus reset) pulls the line low for 480 units and then releases it. It samples the line 70 units after release and finishes 960 units after the start. `presence_o` becomes 1 if the sampled level was low and 0 if it was high.
- R2: Op code 2 (write-1 slot) pulls the line low for 6 units and then releases it for 64 units.
- R3: Op code 1 (write-0 slot) pulls the line low for 60 units and then releases it for 10 units.
- R4: Op code 3 (read slot) pulls the line low for 6 units and samples the line 9 units after release. The slot lasts 70 units in total. `rd_bit_o` returns the sampled level.
- R5: Op code 4 (byte write) sends `data_i` as eight back-to-back write slots, bit 0 first. A bit value of 1 gives a write-1 slot and 0 gives a write-0 slot.
- R6: Op code 5 (byte read) runs eight back-to-back read slots. The first sampled bit lands in bit 0 of `rd_byte_o`.
- R7: One unit is `TICKS_PER_US` × coefficient clocks. The coefficient is `coef_i`, captured when the command is accepted. A value of 0 is treated as 1. Changing `coef_i` during an operation has no effect on it.
- R8: The line is only ever pulled low through `line_oe_o`, and only while the block is busy. When `line_oe_o` is 0 the line is released.
- R9: A request (`start_i`=1) is accepted only while `busy_o` is 0 and `op_i` is 0 to 5. Requests with op codes 6 or 7, and requests made while busy, have no effect. `busy_o` is 1 from the cycle after acceptance until the last slot ends.
- R10: `done_o` is a one-cycle pulse in the cycle after `busy_o` falls. The result outputs keep their values until a later command of the same kind completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command request |
| op_i | input | 3 | Operation code (see R9) |
| data_i | input | 8 | Byte to write |
| coef_i | input | COEF_W | Delay stretch coefficient |
| line_i | input | 1 | Sensed bus level |
| line_oe_o | output | 1 | 1 = pull the bus low, 0 = release |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_bit_o | output | 1 | Result of the last read slot |
| rd_byte_o | output | 8 | Result of the last byte read |
| presence_o | output | 1 | Device answered the last bus reset |

## Verification
The assertions assume that `coef_i` is nonzero once it has been captured, which the engine guarantees by mapping 0 to 1. They also assume that a new slot is launched only when the slot timer is idle or in its final tick. The bench keeps `line_i` consistent with an open-drain wire by driving it from the block's own pull-low enable combined with a modelled device pull. The device pull is held steady across the whole release window of each read slot, and across a presence window around the reset sample point. Because of this, the sampled level never depends on the exact edge the sample is taken on. Requests are driven on falling clock edges, so they are stable at the accepting edge.

// File: rtl/owire_pkg.sv
package owire_pkg;
  localparam int TW = 10;

  typedef enum logic [2:0] {
    OP_RESET  = 3'd0,
    OP_WR0    = 3'd1,
    OP_WR1    = 3'd2,
    OP_RDBIT  = 3'd3,
    OP_WRBYTE = 3'd4,
    OP_RDBYTE = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    SLOT_RST,
    SLOT_W0,
    SLOT_W1,
    SLOT_RD
  } slot_e;

  // low time, low+release-to-sample, total (in units)
  localparam int RST_LOW = 480, RST_SMP = 550, RST_TOT = 960;
  localparam int W0_LOW  = 60,  W0_SMP  = 70,  W0_TOT  = 70;
  localparam int W1_LOW  = 6,   W1_SMP  = 70,  W1_TOT  = 70;
  localparam int RD_LOW  = 6,   RD_SMP  = 15,  RD_TOT  = 70;
endpackage

// File: rtl/owire_tick.sv
module owire_tick #(
  parameter int TICKS_PER_US = 200,
  parameter int COEF_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic              tick_o
);
  localparam int PW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;

  logic [PW-1:0]     pre_q;
  logic [COEF_W-1:0] cc_q;
  logic              pre_last, cc_last;

  assign pre_last = (pre_q == PW'(TICKS_PER_US - 1));
  assign cc_last  = (cc_q == coef_i - COEF_W'(1));
  assign tick_o   = run_i && pre_last && cc_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cc_q  <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      cc_q  <= '0;
    end else begin
      pre_q <= pre_last ? '0 : pre_q + PW'(1);
      if (pre_last) cc_q <= cc_last ? '0 : cc_q + COEF_W'(1);
    end
  end

  a_r7_coef_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> coef_i != '0);
  a_r7_cc_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cc_q < coef_i);
endmodule

// File: rtl/owire_slot.sv
module owire_slot
  import owire_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  go_i,
  input  slot_e kind_i,
  input  logic  tick_i,
  input  logic  line_i,
  output logic  active_o,
  output logic  fin_o,
  output logic  smp_o,
  output logic  line_oe_o
);
  logic          active_q, smp_q;
  logic [TW-1:0] t_q, low_q, smp_at_q, tot_q;
  logic [TW-1:0] low_d, smp_d, tot_d;

  always_comb begin
    unique case (kind_i)
      SLOT_RST: begin low_d = TW'(RST_LOW); smp_d = TW'(RST_SMP); tot_d = TW'(RST_TOT); end
      SLOT_W0:  begin low_d = TW'(W0_LOW);  smp_d = TW'(W0_SMP);  tot_d = TW'(W0_TOT);  end
      SLOT_W1:  begin low_d = TW'(W1_LOW);  smp_d = TW'(W1_SMP);  tot_d = TW'(W1_TOT);  end
      default:  begin low_d = TW'(RD_LOW);  smp_d = TW'(RD_SMP);  tot_d = TW'(RD_TOT);  end
    endcase
  end

  assign fin_o     = active_q && tick_i && (t_q == tot_q - TW'(1));
  assign active_o  = active_q;
  assign smp_o     = smp_q;
  assign line_oe_o = active_q && (t_q < low_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      t_q      <= '0;
      low_q    <= '0;
      smp_at_q <= '0;
      tot_q    <= '0;
      smp_q    <= 1'b0;
    end else begin
      if (active_q && tick_i && (t_q == smp_at_q - TW'(1))) smp_q <= line_i;
      if (go_i) begin
        active_q <= 1'b1;
        t_q      <= '0;
        low_q    <= low_d;
        smp_at_q <= smp_d;
        tot_q    <= tot_d;
      end else if (fin_o) begin
        active_q <= 1'b0;
      end else if (active_q && tick_i) begin
        t_q <= t_q + TW'(1);
      end
    end
  end

  a_r9_go_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (!active_q || fin_o));
  a_r2_release_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $fell(line_oe_o)) |-> (t_q == low_q));
  a_r4_sample_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (smp_at_q > low_q && smp_at_q <= tot_q));
endmodule

// File: rtl/owire_engine.sv
module owire_engine
  import owire_pkg::*;
#(
  parameter int TICKS_PER_US = 200,
  parameter int COEF_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [7:0]        data_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              line_i,
  output logic              line_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_bit_o,
  output logic [7:0]        rd_byte_o,
  output logic              presence_o
);
  localparam int BITS = 8;
  localparam int CW   = $clog2(BITS + 1);

  logic              busy_q, done_q, rd_bit_q, pres_q;
  logic [7:0]        rd_byte_q, sh_q;
  logic [CW-1:0]     left_q;
  logic [COEF_W-1:0] coef_q;
  op_e               op_q;

  logic  accept, last, slot_go, slot_fin, slot_act, slot_smp, tick;
  slot_e k_acc, k_next, kind;

  assign accept  = start_i && !busy_q && (op_i <= 3'd5);
  assign last    = (left_q == CW'(1));
  assign slot_go = accept || (slot_fin && !last);

  always_comb begin
    unique case (op_i)
      3'd0:    k_acc = SLOT_RST;
      3'd1:    k_acc = SLOT_W0;
      3'd2:    k_acc = SLOT_W1;
      3'd4:    k_acc = data_i[0] ? SLOT_W1 : SLOT_W0;
      default: k_acc = SLOT_RD;
    endcase
    k_next = (op_q == OP_WRBYTE) ? (sh_q[1] ? SLOT_W1 : SLOT_W0) : SLOT_RD;
    kind   = accept ? k_acc : k_next;
  end

  owire_tick #(.TICKS_PER_US(TICKS_PER_US), .COEF_W(COEF_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (slot_act),
    .coef_i (coef_q),
    .tick_o (tick)
  );

  owire_slot u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (slot_go),
    .kind_i    (kind),
    .tick_i    (tick),
    .line_i    (line_i),
    .active_o  (slot_act),
    .fin_o     (slot_fin),
    .smp_o     (slot_smp),
    .line_oe_o (line_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      rd_bit_q  <= 1'b0;
      pres_q    <= 1'b0;
      rd_byte_q <= '0;
      sh_q      <= '0;
      left_q    <= '0;
      coef_q    <= COEF_W'(1);
      op_q      <= OP_RESET;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= op_e'(op_i);
        sh_q   <= data_i;
        left_q <= (op_i >= 3'd4) ? CW'(BITS) : CW'(1);
        coef_q <= (coef_i == '0) ? COEF_W'(1) : coef_i;
      end else if (slot_fin) begin
        sh_q   <= {slot_smp, sh_q[7:1]};
        left_q <= left_q - CW'(1);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          unique case (op_q)
            OP_RESET:  pres_q    <= !slot_smp;
            OP_RDBIT:  rd_bit_q  <= slot_smp;
            OP_RDBYTE: rd_byte_q <= {slot_smp, sh_q[7:1]};
            default:   ;
          endcase
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign rd_bit_o   = rd_bit_q;
  assign rd_byte_o  = rd_byte_q;
  assign presence_o = pres_q;

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(busy_o));
  a_r9_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r8_oe_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_oe_o |-> busy_o);
  a_r7_coef_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(coef_q));
  a_r5_slot_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> slot_act);
endmodule

// File: tb/owire_engine_bench.sv
`timescale 1ns/1ps
module owire_engine_bench;
  localparam int TPU = 2;
  localparam int CWB = 4;

  logic           clk = 0, rst_n = 0;
  logic           start = 0;
  logic [2:0]     op = 0;
  logic [7:0]     data = 0;
  logic [CWB-1:0] coef = 1;
  logic           line, oe, busy, done, rbit, pres;
  logic [7:0]     rbyte;
  logic           dev_pull = 0;

  int errors = 0, checks = 0;

  assign line = !(oe || dev_pull);

  owire_engine #(.TICKS_PER_US(TPU), .COEF_W(CWB)) u_owire_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .data_i(data),
    .coef_i(coef), .line_i(line), .line_oe_o(oe), .busy_o(busy), .done_o(done),
    .rd_bit_o(rbit), .rd_byte_o(rbyte), .presence_o(pres)
  );

  always #2.5 clk = ~clk;

  // device behaviour for the next command
  int dev_present = 0;
  logic [7:0] dev_bits = 0;

  // reference model state
  logic acc_seen = 0;
  int m_op, m_data, m_u, m_present;
  logic [7:0] m_bits;
  int m_k = 0;
  bit m_active = 0, exp_busy = 0;
  int e_pres = 0, e_bit = 0, e_byte = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int slot_units(int o);
    return (o == 0) ? 960 : 70;
  endfunction

  function automatic int slot_low(int o, int d, int s);
    case (o)
      0: return 480;
      1: return 60;
      2: return 6;
      4: return d[s] ? 6 : 60;
      default: return 6;
    endcase
  endfunction

  function automatic string op_tag(int o, int u);
    if (u != TPU) return "R7";
    case (o)
      0: return "R1";
      1: return "R3";
      2: return "R2";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // acceptance as defined by R9
  always @(posedge clk) begin
    acc_seen <= start && !exp_busy && (op <= 3'd5) && rst_n;
    if (start && !exp_busy && op <= 3'd5) begin
      m_op      <= op;
      m_data    <= data;
      m_u       <= TPU * ((coef == 0) ? 1 : coef);
      m_present <= dev_present;
      m_bits    <= dev_bits;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int nsl, sl, t, s, o;
      bit e_oe, e_done;
      string tg;
      if (acc_seen) begin m_active = 1; m_k = 0; end
      else if (m_active) m_k++;
      e_oe = 0; e_done = 0; exp_busy = 0; dev_pull = 0; tg = "R8";
      if (m_active) begin
        nsl = (m_op >= 4) ? 8 : 1;
        sl  = slot_units(m_op) * m_u;
        t   = nsl * sl;
        tg  = op_tag(m_op, m_u);
        if (m_k < t) begin
          s = m_k / sl; o = m_k % sl;
          exp_busy = 1;
          e_oe = (o < slot_low(m_op, m_data, s) * m_u);
          if (m_op == 0)
            dev_pull = m_present != 0 && o >= 500 * m_u && o < 580 * m_u;
          else if (m_op == 3 || m_op == 5)
            dev_pull = (o >= 6 * m_u) && !m_bits[s];
        end else begin
          e_done = 1;
          m_active = 0;
          if (m_op == 0) e_pres = m_present;
          if (m_op == 3) e_bit = m_bits[0];
          if (m_op == 5) e_byte = m_bits;
        end
      end
      chk(busy == exp_busy, "R9 busy", busy, exp_busy);
      chk(oe == e_oe, {tg, " line_oe"}, oe, e_oe);
      chk(done == e_done, "R10 done", done, e_done);
      chk(pres == e_pres[0], "R1 presence", pres, e_pres);
      chk(rbit == e_bit[0], "R4 rd_bit", rbit, e_bit);
      chk(rbyte == e_byte[7:0], "R6 rd_byte", rbyte, e_byte);
    end
  end

  task automatic run(input int o, input int d, input int c, input int p, input int b);
    @(negedge clk);
    dev_present = p; dev_bits = b[7:0];
    op = o[2:0]; data = d[7:0]; coef = c[CWB-1:0]; start = 1;
    @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    while (m_active) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && oe == 0 && done == 0, "R9 reset state", busy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(0, 0, 1, 1, 0);        // R1 device present
    run(0, 0, 1, 0, 0);        // R1 no device
    run(2, 0, 1, 0, 0);        // R2
    run(1, 0, 1, 0, 0);        // R3
    run(3, 0, 1, 0, 8'h00);    // R4 read 0
    run(3, 0, 1, 0, 8'h01);    // R4 read 1
    run(4, 8'hA5, 1, 0, 0);    // R5
    run(4, 8'h0E, 1, 0, 0);    // R5 LSB zero first
    run(5, 0, 1, 0, 8'h3C);    // R6
    run(5, 0, 1, 0, 8'hC1);    // R6
    run(2, 0, 3, 0, 0);        // R7 stretched slot
    run(0, 0, 2, 1, 0);        // R7 stretched reset
    run(1, 0, 0, 0, 0);        // R7 coefficient 0 acts as 1
    run(7, 0, 1, 0, 0);        // R9 invalid op ignored
    run(6, 0, 1, 0, 0);        // R9 invalid op ignored
    // R9 request while busy ignored; R7 coef change mid-operation ignored
    fork
      run(4, 8'h5A, 1, 0, 0);
      begin
        repeat (60) @(negedge clk);
        op = 0; coef = 5; start = 1;
        @(negedge clk);
        start = 0;
      end
    join
    run(3, 0, 1, 0, 8'h00);    // R10 results held from earlier ops
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule